// File: doc/BRIEF.md
# Synchronous Master Serial Receiver

This block receives serial data as the clock master of a two-wire synchronous link. It drives the shift clock itself, from a programmable divider off the system clock. It samples the incoming data line on each falling edge of that clock and assembles the bits into words of eight or nine bits. Each finished word moves into a two-entry receive queue. A controller then reads the queue through a simple register-style port.

Two enables start reception. The single-word enable fetches one word and clears itself. The continuous enable keeps fetching words until software clears it. When both are set, the continuous enable wins. The ninth bit travels through the queue with its word. A ready flag and a maskable interrupt tell software that data is waiting. An overrun flag records that a word arrived while the queue was full. While that flag is set, the queue takes no more words. It is cleared by a control write that drops the continuous enable.

Top module: `sync_rx_master`

## Requirements
- R1: After reset, `st_ready`, `st_overrun`, `st_single`, `st_cont`, `irq` and `sck_o` are all 0.
- R2: The shift clock idles low and toggles only while an enable is set. Its period is 2×(divider+1) system clocks.
- R3: `sdat_i` is sampled on each falling edge of `sck_o`, least significant bit first. With `ctl_nine`=0, eight samples form one word.
- R4: With `ctl_nine`=1 a word takes nine samples. The ninth sample is stored as the word's ninth bit, and the first eight form the data.
- R5: In single-word mode (single enable set, continuous enable clear), exactly one word is received. The single enable then reads back 0 and the shift clock stops.
- R6: While the continuous enable is set, words are received back to back.
- R7: With both enables set, reception is continuous. The single enable stays set after a word completes.
- R8: The queue holds two words and returns them in arrival order. `st_ready` is 1 while the queue holds a word, and 0 once reads have emptied it. A read of an empty queue has no effect.
- R9: If a word completes while the queue is full, `st_overrun` becomes 1 and that word is discarded. The stored words are kept.
- R10: While `st_overrun` is 1, completed words never enter the queue. A control write with `ctl_cont`=1 leaves the flag set. A control write with `ctl_cont`=0 clears it, and transfers then resume.
- R11: `st_ninth` shows the ninth bit of the oldest queued word. After a read it moves on to the next word.
- R12: `irq` is 1 exactly when `st_ready` is 1 and the stored interrupt enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control write strobe; loads the four control bits below |
| ctl_single | input | 1 | Single-word receive enable |
| ctl_cont | input | 1 | Continuous receive enable; writing 0 clears overrun |
| ctl_nine | input | 1 | 1 selects 9-bit words |
| ctl_ie | input | 1 | Interrupt enable |
| div_we | input | 1 | Divider write strobe |
| div_wdata | input | DIV_W | Divider value |
| rd_pop | input | 1 | Read strobe; removes the oldest word |
| rd_data | output | DATA_W | Data of the oldest queued word (0 when empty) |
| st_ninth | output | 1 | Ninth bit of the oldest queued word |
| st_ready | output | 1 | Queue holds at least one word |
| st_overrun | output | 1 | Overrun flag |
| st_single | output | 1 | Single enable readback |
| st_cont | output | 1 | Continuous enable readback |
| irq | output | 1 | Interrupt request |
| sck_o | output | 1 | Generated shift clock |
| sdat_i | input | 1 | Serial data in |

## Verification
The hardest state to reach is overrun with a full queue. It needs three complete words to arrive with no read in between. Continuous-mode traffic must then keep arriving, to show that the blocked transfers stay blocked after the queue drains. The bench fills its serial bit queue with three words, lets continuous reception run for 24 falling clock edges, and then drains the queue. It keeps the clock running for two more word times. It then checks that a control write with continuous mode still set keeps the flag. Only then does it clear the continuous enable and confirm that single-word reception delivers data again.

// File: rtl/sync_rx_pkg.sv
`timescale 1ns/1ps
package sync_rx_pkg;
  // shift clock period in system clocks for a given divider value
  function automatic int unsigned sck_period(input int unsigned div);
    return 2 * (div + 1);
  endfunction

  // number of serial samples forming one word
  function automatic int unsigned word_len(input logic nine, input int unsigned dw);
    return nine ? dw + 1 : dw;
  endfunction

  // next pointer of a circular buffer of given depth
  function automatic int unsigned ring_next(input int unsigned p, input int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/sync_rx_clkgen.sv
`timescale 1ns/1ps
module sync_rx_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             sck_o,
  output logic             fall_evt
);
  logic [DIV_W-1:0] cnt_q;
  logic             sck_q;
  logic             at_lim;

  assign at_lim   = (cnt_q == div);
  assign fall_evt = run && at_lim && sck_q;
  assign sck_o    = sck_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else if (at_lim) begin
      cnt_q <= '0;
      sck_q <= ~sck_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sync_rx_shifter.sv
`timescale 1ns/1ps
module sync_rx_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              sample,
  input  logic              sdat,
  input  logic              nine,
  output logic              word_done,
  output logic [DATA_W-1:0] word_data,
  output logic              word_ninth
);
  import sync_rx_pkg::*;
  localparam int CNT_W = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] LAST8 = CNT_W'(word_len(1'b0, DATA_W) - 1);
  localparam logic [CNT_W-1:0] LAST9 = CNT_W'(word_len(1'b1, DATA_W) - 1);

  logic [DATA_W:0]  sh_q;
  logic [DATA_W:0]  sh_next;
  logic [CNT_W-1:0] bit_q;
  logic [CNT_W-1:0] last_idx;

  assign sh_next    = {sdat, sh_q[DATA_W:1]};
  assign last_idx   = nine ? LAST9 : LAST8;
  assign word_done  = sample && (bit_q == last_idx);
  assign word_data  = nine ? sh_next[DATA_W-1:0] : sh_next[DATA_W:1];
  assign word_ninth = nine & sh_next[DATA_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q  <= '0;
      bit_q <= '0;
    end else if (!run) begin
      bit_q <= '0;
    end else if (sample) begin
      sh_q  <= sh_next;
      bit_q <= word_done ? '0 : bit_q + 1'b1;
    end
  end
endmodule

// File: rtl/sync_rx_fifo.sv
`timescale 1ns/1ps
module sync_rx_fifo #(
  parameter int W     = 9,
  parameter int DEPTH = 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic [CNT_W-1:0] fill,
  output logic             full,
  output logic             empty
);
  import sync_rx_pkg::*;
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign fill    = cnt_q;
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = empty ? '0 : mem[rp_q];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= PTR_W'(ring_next(int'(wp_q), DEPTH));
      if (do_pop)  rp_q <= PTR_W'(ring_next(int'(rp_q), DEPTH));
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/sync_rx_master.sv
`timescale 1ns/1ps
module sync_rx_master #(
  parameter int DATA_W     = 8,
  parameter int DIV_W      = 8,
  parameter int FIFO_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic              ctl_single,
  input  logic              ctl_cont,
  input  logic              ctl_nine,
  input  logic              ctl_ie,
  input  logic              div_we,
  input  logic [DIV_W-1:0]  div_wdata,
  input  logic              rd_pop,
  output logic [DATA_W-1:0] rd_data,
  output logic              st_ninth,
  output logic              st_ready,
  output logic              st_overrun,
  output logic              st_single,
  output logic              st_cont,
  output logic              irq,
  output logic              sck_o,
  input  logic              sdat_i
);
  localparam int ENTRY_W = DATA_W + 1;
  localparam int FILL_W  = $clog2(FIFO_DEPTH + 1);

  logic             single_q, cont_q, nine_q, ie_q, ovr_q;
  logic [DIV_W-1:0] div_q;

  // named internal events, observed by the checker
  logic              run;
  logic              fall_evt;
  logic              word_done;
  logic              push_ok;
  logic              fifo_full;
  logic              fifo_empty;
  logic [FILL_W-1:0] fill;
  logic [DATA_W-1:0] word_data;
  logic              word_ninth;
  logic [ENTRY_W-1:0] head;

  assign run     = cont_q | single_q;
  assign push_ok = word_done && !fifo_full && !ovr_q;

  sync_rx_clkgen #(.DIV_W(DIV_W)) clkgen_i (
    .clk(clk), .rst_n(rst_n), .run(run), .div(div_q),
    .sck_o(sck_o), .fall_evt(fall_evt)
  );

  sync_rx_shifter #(.DATA_W(DATA_W)) shifter_i (
    .clk(clk), .rst_n(rst_n), .run(run), .sample(fall_evt),
    .sdat(sdat_i), .nine(nine_q), .word_done(word_done),
    .word_data(word_data), .word_ninth(word_ninth)
  );

  sync_rx_fifo #(.W(ENTRY_W), .DEPTH(FIFO_DEPTH)) fifo_i (
    .clk(clk), .rst_n(rst_n), .push(push_ok), .din({word_ninth, word_data}),
    .pop(rd_pop), .dout(head), .fill(fill), .full(fifo_full), .empty(fifo_empty)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      single_q <= 1'b0;
      cont_q   <= 1'b0;
      nine_q   <= 1'b0;
      ie_q     <= 1'b0;
      ovr_q    <= 1'b0;
      div_q    <= '0;
    end else begin
      if (div_we) div_q <= div_wdata;
      if (ctl_we) begin
        single_q <= ctl_single;
        cont_q   <= ctl_cont;
        nine_q   <= ctl_nine;
        ie_q     <= ctl_ie;
      end else if (word_done && !cont_q) begin
        single_q <= 1'b0;
      end
      if (ctl_we && !ctl_cont)        ovr_q <= 1'b0;
      else if (word_done && fifo_full) ovr_q <= 1'b1;
    end
  end

  assign rd_data    = head[DATA_W-1:0];
  assign st_ninth   = head[DATA_W];
  assign st_ready   = !fifo_empty;
  assign st_overrun = ovr_q;
  assign st_single  = single_q;
  assign st_cont    = cont_q;
  assign irq        = st_ready && ie_q;
endmodule

// File: rtl/sync_rx_checker.sv
`timescale 1ns/1ps
module sync_rx_checker #(
  parameter int FIFO_DEPTH = 2,
  parameter int FILL_W     = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              sck_o,
  input logic              word_done,
  input logic              push_ok,
  input logic              fifo_full,
  input logic [FILL_W-1:0] fill,
  input logic              ctl_we,
  input logic              st_overrun,
  input logic              st_ready,
  input logic              st_single,
  input logic              st_cont,
  input logic              irq
);
  assert_sck_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !sck_o);

  assert_single_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    word_done && st_single && !st_cont && !ctl_we |=> !st_single);

  assert_fill_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FILL_W'(FIFO_DEPTH));

  assert_ready_after_push_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> st_ready);

  assert_overrun_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    word_done && fifo_full && !ctl_we |=> st_overrun);

  assert_no_push_in_overrun_R10: assert property (@(posedge clk) disable iff (!rst_n)
    st_overrun |-> !push_ok);

  assert_irq_needs_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> st_ready);
endmodule

bind sync_rx_master sync_rx_checker #(.FIFO_DEPTH(FIFO_DEPTH), .FILL_W(FILL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .run(run), .sck_o(sck_o), .word_done(word_done),
  .push_ok(push_ok), .fifo_full(fifo_full), .fill(fill), .ctl_we(ctl_we),
  .st_overrun(st_overrun), .st_ready(st_ready), .st_single(st_single),
  .st_cont(st_cont), .irq(irq)
);

// File: tb/sync_rx_master_tb_top.sv
`timescale 1ns/1ps
module sync_rx_master_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_we = 0, ctl_single = 0, ctl_cont = 0, ctl_nine = 0, ctl_ie = 0;
  logic div_we = 0;
  logic [7:0] div_wdata = '0;
  logic rd_pop = 0;
  logic [7:0] rd_data;
  logic st_ninth, st_ready, st_overrun, st_single, st_cont, irq, sck_o;
  logic sdat_i = 1'b0;

  int checks = 0;
  int errors = 0;
  logic bitq[$];
  logic [8:0] expq[$];

  always #5 clk = ~clk;

  sync_rx_master dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_single(ctl_single),
    .ctl_cont(ctl_cont), .ctl_nine(ctl_nine), .ctl_ie(ctl_ie), .div_we(div_we),
    .div_wdata(div_wdata), .rd_pop(rd_pop), .rd_data(rd_data), .st_ninth(st_ninth),
    .st_ready(st_ready), .st_overrun(st_overrun), .st_single(st_single),
    .st_cont(st_cont), .irq(irq), .sck_o(sck_o), .sdat_i(sdat_i)
  );

  // serial driver: next bit presented after each rising shift-clock edge
  initial forever begin
    @(posedge sck_o);
    sdat_i = (bitq.size() > 0) ? bitq.pop_front() : 1'b0;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic s, input logic c, input logic n, input logic ie);
    @(negedge clk);
    ctl_we = 1; ctl_single = s; ctl_cont = c; ctl_nine = n; ctl_ie = ie;
    @(negedge clk);
    ctl_we = 0;
  endtask

  task automatic wr_div(input logic [7:0] d);
    @(negedge clk);
    div_we = 1; div_wdata = d;
    @(negedge clk);
    div_we = 0;
  endtask

  // driver: queue the serial bits (LSB first) and the expected queue entry
  task automatic send_word(input logic [7:0] d, input logic n9, input logic nine, input bit expect_it);
    for (int i = 0; i < 8; i++) bitq.push_back(d[i]);
    if (nine) bitq.push_back(n9);
    if (expect_it) expq.push_back({nine & n9, d});
  endtask

  task automatic wait_falls(input int n);
    repeat (n) @(negedge sck_o);
    repeat (3) @(negedge clk);
  endtask

  // monitor: pop expected entry, compare the queue head, then read it
  task automatic read_check(input string req);
    logic [8:0] e;
    @(negedge clk);
    if (expq.size() == 0) begin
      chk({req, " scoreboard empty"}, 1, 0);
    end else begin
      e = expq.pop_front();
      chk({req, " ready"}, st_ready, 1);
      chk({req, " data"}, rd_data, e[7:0]);
      chk({req, " R11 ninth"}, st_ninth, e[8]);
    end
    rd_pop = 1;
    @(negedge clk);
    rd_pop = 0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    realtime t0, t1;
    bit saw;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", st_ready, 0);
    chk("R1 overrun", st_overrun, 0);
    chk("R1 single", st_single, 0);
    chk("R1 cont", st_cont, 0);
    chk("R1 irq", irq, 0);
    chk("R1 sck", sck_o, 0);

    // R2 idle: no toggles without an enable
    wr_div(8'd2);
    saw = 0;
    repeat (20) begin @(negedge clk); if (sck_o) saw = 1; end
    chk("R2 idle sck", saw, 0);

    // R5 single word, R2 period at divider 2 (6 clocks = 60 ns)
    send_word(8'h5A, 0, 0, 1);
    wr_ctl(1, 0, 0, 0);
    @(posedge sck_o); t0 = $realtime;
    @(posedge sck_o); t1 = $realtime;
    chk("R2 period", int'(t1 - t0), 60);
    wait_falls(7);
    chk("R5 single cleared", st_single, 0);
    chk("R12 irq masked", irq, 0);
    saw = 0;
    repeat (20) begin @(negedge clk); if (sck_o) saw = 1; end
    chk("R5 clock stopped", saw, 0);
    read_check("R3 R5 word");
    chk("R8 ready clear", st_ready, 0);

    // R6 continuous, two words at divider 1, interrupt enabled
    wr_div(8'd1);
    send_word(8'hA5, 0, 0, 1);
    send_word(8'h3C, 0, 0, 1);
    wr_ctl(0, 1, 0, 1);
    wait_falls(16);
    wr_ctl(0, 0, 0, 1);
    chk("R12 irq", irq, 1);
    repeat (4) @(negedge clk);
    chk("R2 stopped after cont clear", sck_o, 0);
    read_check("R3 first");
    chk("R12 irq still", irq, 1);
    read_check("R6 second");
    chk("R8 empty", st_ready, 0);
    chk("R12 irq drop", irq, 0);
    @(negedge clk); rd_pop = 1; @(negedge clk); rd_pop = 0;
    chk("R8 empty pop ignored", st_ready, 0);
    chk("R8 empty pop data", rd_data, 0);

    // R4 / R11 nine-bit words
    send_word(8'hC3, 1, 1, 1);
    send_word(8'h4E, 0, 1, 1);
    wr_ctl(0, 1, 1, 0);
    wait_falls(18);
    wr_ctl(0, 0, 1, 0);
    chk("R11 head ninth", st_ninth, 1);
    read_check("R4 nine first");
    read_check("R4 nine second");

    // R7 both enables: continuous wins
    send_word(8'h96, 0, 0, 1);
    send_word(8'h0F, 0, 0, 1);
    wr_ctl(1, 1, 0, 0);
    wait_falls(16);
    chk("R7 single kept", st_single, 1);
    chk("R7 cont kept", st_cont, 1);
    wr_ctl(0, 0, 0, 0);
    read_check("R7 first");
    read_check("R7 second");

    // R9 / R10 overrun
    send_word(8'h11, 0, 0, 1);
    send_word(8'h22, 0, 0, 1);
    send_word(8'h33, 0, 0, 0);
    wr_ctl(0, 1, 0, 0);
    wait_falls(24);
    chk("R9 overrun set", st_overrun, 1);
    read_check("R9 kept first");
    read_check("R9 kept second");
    chk("R9 third discarded", st_ready, 0);
    wait_falls(16);
    chk("R10 blocked", st_ready, 0);
    wr_ctl(0, 1, 0, 0);
    chk("R10 kept by cont write", st_overrun, 1);
    wr_ctl(0, 0, 0, 0);
    chk("R10 cleared", st_overrun, 0);
    repeat (4) @(negedge clk);
    send_word(8'h77, 0, 0, 1);
    wr_ctl(1, 0, 0, 0);
    wait_falls(8);
    read_check("R10 resumed");

    finish_run();
  end
endmodule